// File: doc/BRIEF.md
# Shared Delay-Line Route Reservation Scheduler

This block books routes through a single-stage optical-style switch fabric. The fabric has NUM_IN input ports, NUM_OUT output ports and NUM_DL recirculating delay lines whose delays are fixed numbers of slots. The block keeps a schedule table with one row per fabric outlet and one column per future timeslot. Each entry names the inlet that feeds that outlet in that slot, or holds an empty code. When a slot begins, the caller presents for every input a new-packet flag, a destination output and a length in slots. The block then walks the inputs in ascending order, one input per clock. For each new packet it either books a complete route or drops the packet.

A route is direct when the destination output is free for the packet's whole length starting at the current slot. Otherwise the packet passes through a chain of one or two delay lines. Every slot of a packet follows the same chain. Every hop must be free for the packet's full length. The search runs breadth-first: it keeps the shallowest depth that has any solution, and within that depth the smallest total delay. The table is a circular buffer. On each slot advance the column of the current slot is presented to the fabric and then cleared for reuse.

Top module: `dlr_scheduler`

## Requirements
- R1: After reset every table entry holds the empty code NUM_IN+NUM_DL (8 by default), busy, res_valid and cfg_valid are low, and the first slot advance presents an all-empty column.
- R2: After slot_start, inputs are processed one per clock from index 0 to NUM_IN-1 and busy is high during that walk. Only inputs whose pkt_new bit was set produce a result, and each result appears on res_* one clock after its input is processed.
- R3: If the destination output is free for len contiguous slots from the current slot, the packet is accepted with res_hops=0 and res_depart equal to the current slot index.
- R4: A delay-line hop, and the output after it, must be free for all len slots of the packet, shifted by the accumulated delay. The same line may be used twice only if its delay is at least len.
- R5: Fewer hops always win. A one-hop route is used only when no direct route exists, and a two-hop route only when no one-hop route exists (default MAX_DEPTH=2).
- R6: Line j delays 2^(j/2) slots (1,1,2,2 by default). Within a depth the route with the smallest total delay is chosen. Ties go to the lowest first-hop line, then the lowest second-hop line. res_depart is the current slot plus the total delay, modulo HORIZON.
- R7: A packet with no route inside MAX_DEPTH returns res_accept=0 and leaves the table unchanged.
- R8: Row r<NUM_DL belongs to delay line r and row NUM_DL+o to output o; in cfg_col, row r sits at bits [r*EW +: EW]. A booked route writes the input index i into the first outlet for len slots, and writes code NUM_IN+j into the next row when that row is fed by line j.
- R9: On slot_start while not busy, cfg_valid pulses for one clock with cfg_col holding the column of the slot just scheduled. That column is cleared and the current slot index advances by one, modulo HORIZON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_start | input | 1 | Begin a new timeslot; sample the request vectors |
| pkt_new | input | NUM_IN | New packet present, one bit per input |
| pkt_dst | input | NUM_IN*OW | Destination output per input, field i at [i*OW +: OW] |
| pkt_len | input | NUM_IN*LW | Length in slots per input, field i at [i*LW +: LW] |
| busy | output | 1 | Input walk in progress |
| res_valid | output | 1 | Result strobe |
| res_port | output | IW | Input the result belongs to |
| res_accept | output | 1 | 1 = route booked, 0 = dropped |
| res_hops | output | 2 | Number of delay lines on the route |
| res_line0 | output | DLW | First delay line used |
| res_line1 | output | DLW | Second delay line used |
| res_depart | output | PW | Slot index at which the packet leaves the output |
| cfg_valid | output | 1 | Column readout strobe |
| cfg_col | output | ROWS*EW | Inlet codes of the column being released to the fabric |

## Verification
The assertions assume that slot_start never arrives while busy is high, and that every flagged packet has a length between 1 and MAX_LEN. The bench therefore issues each slot_start only after the walk of the previous slot has finished, and it uses lengths of 1 to 4. The scenarios keep every booking inside a horizon of sixteen slots. They are ordered so that earlier bookings block later candidates, which forces direct, one-hop and two-hop choices, an equal-delay tie and a drop.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  // Fixed recirculation delay of delay line j, in slots: pairs of lines share 1, 2, 4, ...
  function automatic int line_delay(input int j);
    return 1 << (j >> 1);
  endfunction
endpackage

// File: rtl/dlr_scan.sv
module dlr_scan #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int HORIZON = 16,
  parameter int MAX_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        slot_start,
  input  logic [NUM_IN-1:0]           pkt_new,
  input  logic [NUM_IN*$clog2(NUM_OUT)-1:0]   pkt_dst,
  input  logic [NUM_IN*$clog2(MAX_LEN+1)-1:0] pkt_len,
  output logic                        adv,
  output logic                        busy,
  output logic [$clog2(HORIZON)-1:0]  cur,
  output logic                        proc,
  output logic [$clog2(NUM_IN)-1:0]   proc_in,
  output logic [$clog2(NUM_OUT)-1:0]  proc_dst,
  output logic [$clog2(MAX_LEN+1)-1:0] proc_len
);
  localparam int IW = $clog2(NUM_IN);
  localparam int OW = $clog2(NUM_OUT);
  localparam int LW = $clog2(MAX_LEN+1);
  localparam int PW = $clog2(HORIZON);

  logic              busy_q, busy_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [PW-1:0]     cur_q, cur_d;
  logic [NUM_IN-1:0] new_q, new_d;
  logic [NUM_IN*OW-1:0] dst_q, dst_d;
  logic [NUM_IN*LW-1:0] len_q, len_d;

  assign adv = slot_start && !busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    cur_d  = cur_q;
    new_d  = new_q;
    dst_d  = dst_q;
    len_d  = len_q;
    if (adv) begin
      busy_d = 1'b1;
      idx_d  = '0;
      cur_d  = cur_q + 1'b1;
      new_d  = pkt_new;
      dst_d  = pkt_dst;
      len_d  = pkt_len;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IW'(NUM_IN-1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cur_q  <= '0;
      new_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
    end else if (adv || busy_q) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      cur_q  <= cur_d;
      new_q  <= new_d;
      dst_q  <= dst_d;
      len_q  <= len_d;
    end
  end

  assign busy     = busy_q;
  assign cur      = cur_q;
  assign proc     = busy_q && new_q[idx_q];
  assign proc_in  = idx_q;
  assign proc_dst = dst_q[idx_q*OW +: OW];
  assign proc_len = len_q[idx_q*LW +: LW];
endmodule

// File: rtl/dlr_search.sv
module dlr_search
  import dlr_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_OUT   = 4,
  parameter int NUM_DL    = 4,
  parameter int HORIZON   = 16,
  parameter int MAX_LEN   = 4,
  parameter int MAX_DEPTH = 2
) (
  input  logic [NUM_DL+NUM_OUT-1:0][HORIZON-1:0][$clog2(NUM_IN+NUM_DL+1)-1:0] tbl,
  input  logic [$clog2(HORIZON)-1:0]   cur,
  input  logic [$clog2(NUM_OUT)-1:0]   dst,
  input  logic [$clog2(MAX_LEN+1)-1:0] len,
  output logic                         found,
  output logic [1:0]                   hops,
  output logic [$clog2(NUM_DL)-1:0]    l0,
  output logic [$clog2(NUM_DL)-1:0]    l1,
  output logic [$clog2(HORIZON)-1:0]   tdel
);
  localparam int EW  = $clog2(NUM_IN+NUM_DL+1);
  localparam int PW  = $clog2(HORIZON);
  localparam int DLW = $clog2(NUM_DL);
  localparam logic [EW-1:0] EMPTY_C = EW'(NUM_IN+NUM_DL);

  // True when outlet row is free for len slots starting off slots after cur.
  function automatic logic seg_free(input int row, input int off);
    logic ok;
    logic [PW-1:0] col;
    ok = 1'b1;
    for (int k = 0; k < MAX_LEN; k++) begin
      col = cur + PW'(off) + PW'(k);
      if (k < int'(len) && tbl[row][col] != EMPTY_C) ok = 1'b0;
    end
    return ok;
  endfunction

  logic f0, f1, f2;
  int   b1l, b1d, b2a, b2b, b2d;
  int   orow;

  always_comb begin
    orow = NUM_DL + int'(dst);
    f0 = seg_free(orow, 0);
    f1 = 1'b0; b1l = 0; b1d = 0;
    for (int j = 0; j < NUM_DL; j++) begin
      if (seg_free(j, 0) && seg_free(orow, line_delay(j)) &&
          (!f1 || line_delay(j) < b1d)) begin
        f1 = 1'b1; b1l = j; b1d = line_delay(j);
      end
    end
    f2 = 1'b0; b2a = 0; b2b = 0; b2d = 0;
    for (int j = 0; j < NUM_DL; j++) begin
      for (int k = 0; k < NUM_DL; k++) begin
        if ((j != k || int'(len) <= line_delay(j)) &&
            seg_free(j, 0) && seg_free(k, line_delay(j)) &&
            seg_free(orow, line_delay(j) + line_delay(k)) &&
            (!f2 || line_delay(j) + line_delay(k) < b2d)) begin
          f2 = 1'b1; b2a = j; b2b = k; b2d = line_delay(j) + line_delay(k);
        end
      end
    end
  end

  always_comb begin
    found = 1'b0; hops = 2'd0; l0 = '0; l1 = '0; tdel = '0;
    if (f0) begin
      found = 1'b1;
    end else if (MAX_DEPTH >= 1 && f1) begin
      found = 1'b1; hops = 2'd1; l0 = DLW'(b1l); tdel = PW'(b1d);
    end else if (MAX_DEPTH >= 2 && f2) begin
      found = 1'b1; hops = 2'd2; l0 = DLW'(b2a); l1 = DLW'(b2b); tdel = PW'(b2d);
    end
  end
endmodule

// File: rtl/dlr_table.sv
module dlr_table
  import dlr_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int NUM_DL  = 4,
  parameter int HORIZON = 16,
  parameter int MAX_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic [$clog2(HORIZON)-1:0]   cur,
  input  logic                         wr,
  input  logic [$clog2(NUM_IN)-1:0]    src,
  input  logic [$clog2(NUM_OUT)-1:0]   dst,
  input  logic [$clog2(MAX_LEN+1)-1:0] len,
  input  logic [1:0]                   hops,
  input  logic [$clog2(NUM_DL)-1:0]    l0,
  input  logic [$clog2(NUM_DL)-1:0]    l1,
  output logic [NUM_DL+NUM_OUT-1:0][HORIZON-1:0][$clog2(NUM_IN+NUM_DL+1)-1:0] tbl,
  output logic                         cfg_valid,
  output logic [(NUM_DL+NUM_OUT)*$clog2(NUM_IN+NUM_DL+1)-1:0] cfg_col
);
  localparam int ROWS = NUM_DL + NUM_OUT;
  localparam int EW   = $clog2(NUM_IN+NUM_DL+1);
  localparam int PW   = $clog2(HORIZON);
  localparam logic [EW-1:0] EMPTY_C = EW'(NUM_IN+NUM_DL);

  logic [ROWS-1:0][HORIZON-1:0][EW-1:0] tbl_q, tbl_d;
  logic [ROWS*EW-1:0] col_now;
  logic [EW-1:0] src_c, l0_c, l1_c;
  int d0, d1, orow;
  logic [PW-1:0] c0, c1, c2;

  assign src_c = EW'(src);
  assign l0_c  = EW'(NUM_IN) + EW'(l0);
  assign l1_c  = EW'(NUM_IN) + EW'(l1);

  always_comb begin
    for (int r = 0; r < ROWS; r++) col_now[r*EW +: EW] = tbl_q[r][cur];
  end

  always_comb begin
    tbl_d = tbl_q;
    d0 = line_delay(int'(l0));
    d1 = line_delay(int'(l1));
    orow = NUM_DL + int'(dst);
    if (clr) begin
      for (int r = 0; r < ROWS; r++) tbl_d[r][cur] = EMPTY_C;
    end
    for (int k = 0; k < MAX_LEN; k++) begin
      c0 = cur + PW'(k);
      c1 = cur + PW'(d0) + PW'(k);
      c2 = cur + PW'(d0 + d1) + PW'(k);
      if (wr && k < int'(len)) begin
        case (hops)
          2'd0: tbl_d[orow][c0] = src_c;
          2'd1: begin
            tbl_d[l0][c0]   = src_c;
            tbl_d[orow][c1] = l0_c;
          end
          default: begin
            tbl_d[l0][c0]   = src_c;
            tbl_d[l1][c1]   = l0_c;
            tbl_d[orow][c2] = l1_c;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < HORIZON; c++) tbl_q[r][c] <= EMPTY_C;
    end else if (clr || wr) begin
      tbl_q <= tbl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      cfg_col   <= '0;
    end else begin
      cfg_valid <= clr;
      if (clr) cfg_col <= col_now;
    end
  end

  assign tbl = tbl_q;
endmodule

// File: rtl/dlr_scheduler.sv
module dlr_scheduler #(
  parameter int NUM_IN    = 4,
  parameter int NUM_OUT   = 4,
  parameter int NUM_DL    = 4,
  parameter int HORIZON   = 16,
  parameter int MAX_LEN   = 4,
  parameter int MAX_DEPTH = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         slot_start,
  input  logic [NUM_IN-1:0]                            pkt_new,
  input  logic [NUM_IN*$clog2(NUM_OUT)-1:0]            pkt_dst,
  input  logic [NUM_IN*$clog2(MAX_LEN+1)-1:0]          pkt_len,
  output logic                                         busy,
  output logic                                         res_valid,
  output logic [$clog2(NUM_IN)-1:0]                    res_port,
  output logic                                         res_accept,
  output logic [1:0]                                   res_hops,
  output logic [$clog2(NUM_DL)-1:0]                    res_line0,
  output logic [$clog2(NUM_DL)-1:0]                    res_line1,
  output logic [$clog2(HORIZON)-1:0]                   res_depart,
  output logic                                         cfg_valid,
  output logic [(NUM_DL+NUM_OUT)*$clog2(NUM_IN+NUM_DL+1)-1:0] cfg_col
);
  localparam int ROWS = NUM_DL + NUM_OUT;
  localparam int EW   = $clog2(NUM_IN+NUM_DL+1);
  localparam int IW   = $clog2(NUM_IN);
  localparam int OW   = $clog2(NUM_OUT);
  localparam int LW   = $clog2(MAX_LEN+1);
  localparam int PW   = $clog2(HORIZON);
  localparam int DLW  = $clog2(NUM_DL);

  logic adv, proc, found;
  logic [PW-1:0] cur, tdel;
  logic [IW-1:0] proc_in;
  logic [OW-1:0] proc_dst;
  logic [LW-1:0] proc_len;
  logic [1:0] hops;
  logic [DLW-1:0] l0, l1;
  logic [ROWS-1:0][HORIZON-1:0][EW-1:0] tbl;

  dlr_scan #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .HORIZON(HORIZON), .MAX_LEN(MAX_LEN)) u_scan (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .pkt_new(pkt_new),
    .pkt_dst(pkt_dst), .pkt_len(pkt_len), .adv(adv), .busy(busy), .cur(cur),
    .proc(proc), .proc_in(proc_in), .proc_dst(proc_dst), .proc_len(proc_len));

  dlr_search #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_DL(NUM_DL), .HORIZON(HORIZON),
               .MAX_LEN(MAX_LEN), .MAX_DEPTH(MAX_DEPTH)) u_search (
    .tbl(tbl), .cur(cur), .dst(proc_dst), .len(proc_len),
    .found(found), .hops(hops), .l0(l0), .l1(l1), .tdel(tdel));

  dlr_table #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_DL(NUM_DL), .HORIZON(HORIZON),
              .MAX_LEN(MAX_LEN)) u_table (
    .clk(clk), .rst_n(rst_n), .clr(adv), .cur(cur), .wr(proc && found),
    .src(proc_in), .dst(proc_dst), .len(proc_len), .hops(hops), .l0(l0), .l1(l1),
    .tbl(tbl), .cfg_valid(cfg_valid), .cfg_col(cfg_col));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_port   <= '0;
      res_accept <= 1'b0;
      res_hops   <= '0;
      res_line0  <= '0;
      res_line1  <= '0;
      res_depart <= '0;
    end else begin
      res_valid <= proc;
      if (proc) begin
        res_port   <= proc_in;
        res_accept <= found;
        res_hops   <= hops;
        res_line0  <= l0;
        res_line1  <= l1;
        res_depart <= cur + tdel;
      end
    end
  end
endmodule

// File: rtl/dlr_scheduler_chk.sv
module dlr_scheduler_chk #(
  parameter int NUM_IN    = 4,
  parameter int MAX_LEN   = 4,
  parameter int MAX_DEPTH = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                slot_start,
  input logic [NUM_IN-1:0]                   pkt_new,
  input logic [NUM_IN*$clog2(MAX_LEN+1)-1:0] pkt_len,
  input logic                                busy,
  input logic                                res_valid,
  input logic [$clog2(NUM_IN)-1:0]           res_port,
  input logic                                res_accept,
  input logic [1:0]                          res_hops,
  input logic                                cfg_valid
);
  localparam int LW = $clog2(MAX_LEN+1);
  localparam int IW = $clog2(NUM_IN);

  logic len_bad;
  always_comb begin
    len_bad = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      if (pkt_new[i] && (pkt_len[i*LW +: LW] == '0 || int'(pkt_len[i*LW +: LW]) > MAX_LEN))
        len_bad = 1'b1;
  end

  // R9 (input assumption: a slot never starts during a walk)
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !slot_start);

  // R2 (input assumption: lengths within 1..MAX_LEN)
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> !len_bad);

  // R2
  result_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));

  // R2
  ascending_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |-> res_port == IW'($past(res_port) + 1'b1));

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_accept) |-> int'(res_hops) <= MAX_DEPTH);

  // R9
  readout_on_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $past(slot_start && !busy));
endmodule

bind dlr_scheduler dlr_scheduler_chk #(.NUM_IN(NUM_IN), .MAX_LEN(MAX_LEN), .MAX_DEPTH(MAX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .pkt_new(pkt_new), .pkt_len(pkt_len),
  .busy(busy), .res_valid(res_valid), .res_port(res_port), .res_accept(res_accept),
  .res_hops(res_hops), .cfg_valid(cfg_valid));

// File: tb/test_dlr_scheduler.sv
`timescale 1ns/1ps
module test_dlr_scheduler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_start = 1'b0;
  logic [3:0]  pkt_new = '0;
  logic [7:0]  pkt_dst = '0;
  logic [11:0] pkt_len = '0;
  logic busy, res_valid, res_accept, cfg_valid;
  logic [1:0] res_port, res_hops, res_line0, res_line1;
  logic [3:0] res_depart;
  logic [31:0] cfg_col;

  always #2.5 clk = ~clk;

  dlr_scheduler i_dlr_scheduler (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .pkt_new(pkt_new),
    .pkt_dst(pkt_dst), .pkt_len(pkt_len), .busy(busy), .res_valid(res_valid),
    .res_port(res_port), .res_accept(res_accept), .res_hops(res_hops),
    .res_line0(res_line0), .res_line1(res_line1), .res_depart(res_depart),
    .cfg_valid(cfg_valid), .cfg_col(cfg_col));

  typedef struct {
    string tag; int port; bit acc; int hops; int l0; int l1; int dep;
  } res_t;
  typedef struct { string tag; bit chk; logic [31:0] col; } col_t;

  res_t res_q[$];
  col_t col_q[$];
  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic exp_res(input string tag, input int port, input bit acc,
                         input int hops, input int l0, input int l1, input int dep);
    res_t e;
    e.tag = tag; e.port = port; e.acc = acc; e.hops = hops; e.l0 = l0; e.l1 = l1; e.dep = dep;
    res_q.push_back(e);
  endtask

  task automatic exp_col(input string tag, input bit chk, input logic [31:0] col);
    col_t e;
    e.tag = tag; e.chk = chk; e.col = col;
    col_q.push_back(e);
  endtask

  // Driver: one slot request, then wait for the walk of 4 inputs to finish.
  task automatic run_slot(input logic [3:0] nw, input logic [7:0] dst, input logic [11:0] len);
    @(negedge clk);
    slot_start = 1'b1; pkt_new = nw; pkt_dst = dst; pkt_len = len;
    @(negedge clk);
    slot_start = 1'b0; pkt_new = '0;
    repeat (6) @(negedge clk);
  endtask

  // Monitor: compare results and column readouts as they appear.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (res_q.size() == 0) begin
        check(1'b0, "R2", "unexpected result port", 32'(res_port), 32'hFFFF_FFFF);
      end else begin
        res_t e;
        bit ok;
        e = res_q.pop_front();
        ok = (int'(res_port) == e.port) && (res_accept == e.acc);
        if (e.acc) begin
          ok = ok && int'(res_hops) == e.hops && int'(res_depart) == e.dep;
          if (e.hops >= 1) ok = ok && int'(res_line0) == e.l0;
          if (e.hops == 2) ok = ok && int'(res_line1) == e.l1;
        end
        check(ok, e.tag, "result {port,acc,hops,l0,l1,dep}",
              {8'(res_port), 4'(res_accept), 4'(res_hops), 4'(res_line0), 4'(res_line1), 8'(res_depart)},
              {8'(e.port), 4'(e.acc), 4'(e.hops), 4'(e.l0), 4'(e.l1), 8'(e.dep)});
      end
    end
    if (rst_n && cfg_valid) begin
      if (col_q.size() == 0) begin
        check(1'b0, "R9", "unexpected readout", cfg_col, 32'h0);
      end else begin
        col_t c;
        c = col_q.pop_front();
        if (c.chk) check(cfg_col == c.col, c.tag, "column readout", cfg_col, c.col);
      end
    end
  end

  bit finished = 1'b0;
  initial begin
    #(200000 * 5);
    if (!finished) begin
      check(1'b0, "R2", "watchdog expired", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'h0);
    check(res_valid == 1'b0, "R1", "res_valid after reset", 32'(res_valid), 32'h0);
    check(cfg_valid == 1'b0, "R1", "cfg_valid after reset", 32'(cfg_valid), 32'h0);

    // Slot A (current slot 1). R1: readout of column 0 is all empty.
    exp_col("R1", 1'b1, 32'h8888_8888);
    exp_res("R3", 0, 1'b1, 0, 0, 0, 1);   // direct to out0 for 3 slots
    exp_res("R5", 1, 1'b1, 2, 0, 2, 4);   // only two hops reach out0 slot 4
    exp_res("R2", 2, 1'b1, 0, 0, 0, 1);   // direct to out1
    run_slot(4'b0111, {2'd0, 2'd1, 2'd0, 2'd0}, {3'd0, 3'd1, 3'd2, 3'd3});

    // Slot B (current slot 2). R8: column 1 encodes input and output entries.
    exp_col("R8", 1'b1, 32'h8820_8881);
    exp_res("R3", 0, 1'b1, 0, 0, 0, 2);   // direct to out2 for 4 slots
    exp_res("R6", 3, 1'b1, 2, 3, 2, 6);   // smallest total delay 4, lines 3 then 2
    run_slot(4'b1001, {2'd0, 2'd0, 2'd0, 2'd2}, {3'd1, 3'd0, 3'd0, 3'd4});

    // Slot C (current slot 3). R8: column 2 holds delay-line inlet codes.
    exp_col("R8", 1'b1, 32'h8080_3481);
    exp_res("R4", 1, 1'b1, 2, 3, 2, 7);   // line 2 busy at slot 3, route via line 3
    exp_res("R7", 2, 1'b0, 0, 0, 0, 0);   // out0 booked through slot 7: drop
    run_slot(4'b0110, {2'd0, 2'd0, 2'd0, 2'd0}, {3'd0, 3'd1, 3'd1, 3'd0});

    // Slot D (current slot 4). R7: column 3 shows nothing from the dropped packet.
    exp_col("R7", 1'b1, 32'h8080_1488);
    exp_res("R3", 0, 1'b1, 0, 0, 0, 4);
    exp_res("R6", 1, 1'b1, 1, 0, 0, 5);   // equal-delay tie goes to line 0
    exp_res("R4", 2, 1'b1, 1, 3, 0, 6);   // line 0 and line 2 busy, line 3 used
    run_slot(4'b0111, {2'd0, 2'd3, 2'd3, 2'd3}, {3'd0, 3'd1, 3'd1, 3'd1});

    // Empty slots until the buffer wraps to column 1 again. R9: it was cleared.
    for (int s = 5; s <= 17; s++) begin
      exp_col("R9", 1'b0, 32'h0);
      run_slot(4'b0000, 8'h00, 12'h000);
    end
    exp_col("R9", 1'b1, 32'h8888_8888);
    run_slot(4'b0000, 8'h00, 12'h000);

    // R2: every expected result and readout was produced
    check(res_q.size() == 0 && col_q.size() == 0, "R2", "pending expectations",
          32'(res_q.size() + col_q.size()), 32'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule